// File: doc/BRIEF.md
# Receive Ring Flow-Control Monitor

This block watches a circular receive buffer held in MAC memory and decides when the link partner has to be slowed down. The ring spans the addresses from a base address up to, but not including, a top address. A write pointer, owned by the block, moves forward by one packet slot each time the receive DMA reports a stored packet. A read pointer is loaded by software whenever it consumes packets. From the distance between the two pointers the block reports how many packet slots are still free.

A single 8-bit buffer-size setting carries two fields. Its upper two bits pick the packet slot size; its lower six bits hold a threshold. A threshold of zero turns hardware flow control off. Any other value arms it: once the free-slot count is below the threshold, the block either raises a one-cycle pause-frame request (full duplex) or holds a jam request for as long as the shortage lasts (half duplex). The frames, the MII side and the DMA data path sit elsewhere.

The request logic is a four-state machine. `FC_OPEN` means no shortage. `FC_PAUSE` lasts one cycle and emits the pause request. `FC_HOLD` is a full-duplex shortage that has already been signalled. `FC_JAM` is a half-duplex shortage that drives the jam request. Transitions, evaluated on each clock from the shortage flag `below` and `full_duplex`: OPEN to PAUSE (shortage, full duplex); PAUSE to HOLD (shortage persists, full duplex); HOLD stays HOLD; JAM to HOLD (duplex changed to full, shortage persists); any state to JAM (shortage, half duplex); any state to OPEN (no shortage).

Top module: `rx_ring_flowctl`

## Requirements
- R1: While `rst_n` is low, `wr_ptr` is loaded with `cfg_base` and the internal read pointer is set to `cfg_base` as well. After release, `free_slots` therefore equals the full ring slot count, and `pause_req` and `jam_req` are low.
- R2: `cfg_bufsize[7:6]` selects the slot size: 00 gives 256 bytes, 01 gives 128, 10 gives 64 and 11 gives 32. `free_slots` equals ((read − write) modulo (`cfg_top` − `cfg_base`)) divided by the slot size. Equal pointers count as the whole ring being free.
- R3: A one-cycle `dma_store` high advances `wr_ptr` by one slot at the next clock edge. Without `dma_store`, `wr_ptr` holds its value.
- R4: When an advance reaches or passes `cfg_top`, `wr_ptr` wraps by the ring length, so it stays within [`cfg_base`, `cfg_top`).
- R5: With `sw_rd_we` high, the read pointer takes `sw_rd_ptr` at the clock edge, and `free_slots` reflects the new value after that edge.
- R6: When `cfg_bufsize[5:0]` is zero, `pause_req` and `jam_req` stay low whatever the free count is.
- R7: In full duplex, `pause_req` is high for exactly one cycle, one clock after `free_slots` first falls below a nonzero threshold. It is not repeated while the shortage persists.
- R8: In half duplex, `jam_req` is high from one clock after `free_slots` falls below the threshold until one clock after it no longer does.
- R9: `pause_req` and `jam_req` are never high together. A change from half to full duplex during a shortage drops `jam_req` and raises no pause request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W | First address of the ring |
| cfg_top | input | ADDR_W | One past the last address of the ring |
| cfg_bufsize | input | 8 | [7:6] slot size select, [5:0] flow-control threshold |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| dma_store | input | 1 | One-cycle strobe: a packet was stored in the next slot |
| sw_rd_we | input | 1 | Load strobe for the read pointer |
| sw_rd_ptr | input | ADDR_W | New read pointer value |
| wr_ptr | output | ADDR_W | Current hardware write pointer |
| free_slots | output | ADDR_W | Count of free packet slots |
| pause_req | output | 1 | One-cycle request for a pause control frame |
| jam_req | output | 1 | Level request to jam the channel |

## Verification
The hardest situations to reach are a wrap of the write pointer at the top address while the ring is nearly full, and a duplex change in the middle of a shortage. Both depend on a long, consistent history of stores and software consumption. The stimulus plays the role of a well-behaved producer and consumer: stores are issued only while more than one slot is free, and consumption never passes the write pointer. This lets random runs cross the threshold many times in both directions. Directed sequences fill the ring to one free slot, drain it, wrap the pointer, and then flip `full_duplex` while jam is active.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
    typedef enum logic [1:0] {
        FC_OPEN  = 2'd0,
        FC_PAUSE = 2'd1,
        FC_HOLD  = 2'd2,
        FC_JAM   = 2'd3
    } fc_state_e;

    // slot size select 0..3 maps to 256,128,64,32 bytes (log2: 8..5)
    function automatic logic [3:0] slot_shift(input logic [1:0] sel);
        return 4'd8 - {2'b00, sel};
    endfunction
endpackage

// File: rtl/rx_ring_wrptr.sv
module rx_ring_wrptr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] top,
    input  logic [3:0]        shift,
    input  logic              store,
    output logic [ADDR_W-1:0] wr_ptr
);
    localparam logic [ADDR_W:0] ONE = (ADDR_W+1)'(1);

    logic [ADDR_W-1:0] ring_len;
    logic [ADDR_W:0]   step_sum;
    logic [ADDR_W:0]   wrapped;

    always_comb begin
        ring_len = top - base;
        step_sum = {1'b0, wr_ptr} + (ONE << shift);
        if (step_sum >= {1'b0, top}) begin
            wrapped = step_sum - {1'b0, ring_len};
        end else begin
            wrapped = step_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= base;
        end else if (store) begin
            wr_ptr <= wrapped[ADDR_W-1:0];
        end
    end
endmodule

// File: rtl/rx_ring_space.sv
module rx_ring_space #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] top,
    input  logic [3:0]        shift,
    input  logic              sw_we,
    input  logic [ADDR_W-1:0] sw_ptr,
    input  logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] free_slots
);
    logic [ADDR_W-1:0] rd_ptr;
    logic [ADDR_W-1:0] ring_len;
    logic [ADDR_W-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= base;
        end else if (sw_we) begin
            rd_ptr <= sw_ptr;
        end
    end

    always_comb begin
        ring_len = top - base;
        if (rd_ptr > wr_ptr) begin
            gap = rd_ptr - wr_ptr;
        end else if (rd_ptr < wr_ptr) begin
            gap = rd_ptr + ring_len - wr_ptr;
        end else begin
            gap = ring_len;
        end
        free_slots = gap >> shift;
    end
endmodule

// File: rtl/rx_ring_fc_fsm.sv
module rx_ring_fc_fsm
    import rx_ring_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic below,
    input  logic full_duplex,
    output logic pause_req,
    output logic jam_req
);
    fc_state_e state_q;
    fc_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FC_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!below) begin
            state_d = FC_OPEN;
        end else if (!full_duplex) begin
            state_d = FC_JAM;
        end else begin
            unique case (state_q)
                FC_OPEN:  state_d = FC_PAUSE;
                FC_PAUSE: state_d = FC_HOLD;
                FC_HOLD:  state_d = FC_HOLD;
                FC_JAM:   state_d = FC_HOLD;
                default:  state_d = FC_OPEN;
            endcase
        end
    end

    always_comb begin
        pause_req = 1'b0;
        jam_req   = 1'b0;
        unique case (state_q)
            FC_OPEN:  ;
            FC_PAUSE: pause_req = 1'b1;
            FC_HOLD:  ;
            FC_JAM:   jam_req = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/rx_ring_flowctl.sv
module rx_ring_flowctl
    import rx_ring_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_top,
    input  logic [7:0]        cfg_bufsize,
    input  logic              full_duplex,
    input  logic              dma_store,
    input  logic              sw_rd_we,
    input  logic [ADDR_W-1:0] sw_rd_ptr,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] free_slots,
    output logic              pause_req,
    output logic              jam_req
);
    localparam int THR_W = 6;

    logic [3:0]       shift;
    logic [THR_W-1:0] thr;
    logic             below;

    assign shift = slot_shift(cfg_bufsize[7:6]);
    assign thr   = cfg_bufsize[THR_W-1:0];
    assign below = (thr != '0) && (free_slots < ADDR_W'(thr));

    rx_ring_wrptr #(.ADDR_W(ADDR_W)) u_wrptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .base   (cfg_base),
        .top    (cfg_top),
        .shift  (shift),
        .store  (dma_store),
        .wr_ptr (wr_ptr)
    );

    rx_ring_space #(.ADDR_W(ADDR_W)) u_space (
        .clk        (clk),
        .rst_n      (rst_n),
        .base       (cfg_base),
        .top        (cfg_top),
        .shift      (shift),
        .sw_we      (sw_rd_we),
        .sw_ptr     (sw_rd_ptr),
        .wr_ptr     (wr_ptr),
        .free_slots (free_slots)
    );

    rx_ring_fc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .below       (below),
        .full_duplex (full_duplex),
        .pause_req   (pause_req),
        .jam_req     (jam_req)
    );
endmodule

// File: rtl/rx_ring_flowctl_chk.sv
module rx_ring_flowctl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cfg_base,
    input logic [ADDR_W-1:0] cfg_top,
    input logic [7:0]        cfg_bufsize,
    input logic              dma_store,
    input logic [ADDR_W-1:0] wr_ptr,
    input logic              pause_req,
    input logic              jam_req
);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_store |=> $stable(wr_ptr));

    p_in_ring_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr >= cfg_base) && (wr_ptr < cfg_top));

    p_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bufsize[5:0] == 6'd0) |=> (!pause_req && !jam_req));

    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |=> !pause_req);

    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pause_req && jam_req));
endmodule

bind rx_ring_flowctl rx_ring_flowctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_base    (cfg_base),
    .cfg_top     (cfg_top),
    .cfg_bufsize (cfg_bufsize),
    .dma_store   (dma_store),
    .wr_ptr      (wr_ptr),
    .pause_req   (pause_req),
    .jam_req     (jam_req)
);

// File: tb/rx_ring_flowctl_tb.sv
`timescale 1ns/1ps
module rx_ring_flowctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_base = 16'h0100;
    logic [15:0] cfg_top = 16'h0900;
    logic [7:0]  cfg_bufsize = 8'h03;
    logic        full_duplex = 1'b1;
    logic        dma_store = 1'b0;
    logic        sw_rd_we = 1'b0;
    logic [15:0] sw_rd_ptr = 16'h0;
    logic [15:0] wr_ptr;
    logic [15:0] free_slots;
    logic        pause_req;
    logic        jam_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int m_wr, m_rd, m_st;

    always #2.5 clk = ~clk;

    rx_ring_flowctl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_top(cfg_top),
        .cfg_bufsize(cfg_bufsize), .full_duplex(full_duplex),
        .dma_store(dma_store), .sw_rd_we(sw_rd_we), .sw_rd_ptr(sw_rd_ptr),
        .wr_ptr(wr_ptr), .free_slots(free_slots),
        .pause_req(pause_req), .jam_req(jam_req)
    );

    function automatic int slot_bytes();
        return 256 >> cfg_bufsize[7:6];
    endfunction

    function automatic int ring_len();
        return int'(cfg_top) - int'(cfg_base);
    endfunction

    function automatic int total_slots();
        return ring_len() / slot_bytes();
    endfunction

    function automatic int model_free();
        int gap;
        if (m_rd > m_wr) gap = m_rd - m_wr;
        else if (m_rd < m_wr) gap = m_rd + ring_len() - m_wr;
        else gap = ring_len();
        return gap / slot_bytes();
    endfunction

    function automatic bit model_below();
        int thr = int'(cfg_bufsize[5:0]);
        return (thr != 0) && (model_free() < thr);
    endfunction

    function automatic int adv(input int p, input int k);
        int s = p + k * slot_bytes();
        if (s >= int'(cfg_top)) s -= ring_len();
        return s;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic do_reset(input logic [15:0] b, input logic [15:0] t,
                            input logic [7:0] bs, input logic fd);
        rst_n = 1'b0;
        cfg_base = b; cfg_top = t; cfg_bufsize = bs; full_duplex = fd;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_wr = int'(b); m_rd = int'(b); m_st = 0;
        @(negedge clk);
        check("R1 wr_ptr", int'(wr_ptr), int'(b));
        check("R1 free_slots", int'(free_slots), total_slots());
        check("R1 pause_req", int'(pause_req), 0);
        check("R1 jam_req", int'(jam_req), 0);
    endtask

    task automatic do_cycle(input bit st, input bit rwe, input int rv,
                            input string ptag, input string qtag);
        bit low;
        bit fdv;
        low = model_below();
        fdv = full_duplex;
        dma_store = st; sw_rd_we = rwe; sw_rd_ptr = 16'(rv);
        @(posedge clk);
        #1;
        if (low && fdv) m_st = (m_st == 0) ? 1 : 2;
        else if (low) m_st = 3;
        else m_st = 0;
        if (st) m_wr = adv(m_wr, 1);
        if (rwe) m_rd = rv;
        @(negedge clk);
        dma_store = 1'b0; sw_rd_we = 1'b0;
        check({ptag, " wr_ptr"}, int'(wr_ptr), m_wr);
        check("R2 free_slots", int'(free_slots), model_free());
        check({qtag, " pause_req"}, int'(pause_req), int'(m_st == 1));
        check({qtag, " jam_req"}, int'(jam_req), int'(m_st == 3));
    endtask

    task automatic random_run(input int n, input bit flip_fd, input string qtag);
        for (int i = 0; i < n; i++) begin
            bit st;
            bit rwe;
            int rv;
            int used;
            if (flip_fd && ($urandom % 37 == 0)) full_duplex = ~full_duplex;
            st = ($urandom % 3 == 0) && (model_free() > 1);
            used = (m_rd == m_wr) ? 0 : total_slots() - model_free();
            rwe = ($urandom % 4 == 0) && (used > 0);
            rv = rwe ? adv(m_rd, 1 + int'($urandom % used)) : m_rd;
            do_cycle(st, rwe, rv, st ? "R3" : "R3 hold", rwe ? "R5" : qtag);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);

        // Directed: 256-byte slots, 8 slots, threshold 3, full duplex
        do_reset(16'h0100, 16'h0900, 8'h03, 1'b1);
        for (int i = 0; i < 7; i++) do_cycle(1'b1, 1'b0, m_rd, "R3", "R7");
        check("R3 filled wr_ptr", int'(wr_ptr), 16'h0800);
        check("R2 one slot free", int'(free_slots), 1);
        do_cycle(1'b0, 1'b0, m_rd, "R3 hold", "R7 no repeat");
        do_cycle(1'b0, 1'b1, 16'h0800, "R3 hold", "R5");
        check("R5 drained free", int'(free_slots), 8);
        do_cycle(1'b1, 1'b0, m_rd, "R4", "R7");
        check("R4 wrapped wr_ptr", int'(wr_ptr), 16'h0100);

        // Random: full duplex with occasional duplex flips
        random_run(600, 1'b1, "R7");

        // Directed: 32-byte slots, 16 slots, threshold 5, half duplex
        do_reset(16'h0100, 16'h0300, 8'hC5, 1'b0);
        for (int i = 0; i < 13; i++) do_cycle(1'b1, 1'b0, m_rd, "R3", "R8");
        do_cycle(1'b0, 1'b0, m_rd, "R3 hold", "R8");
        check("R8 jam held", int'(jam_req), 1);
        full_duplex = 1'b1;
        do_cycle(1'b0, 1'b0, m_rd, "R3 hold", "R9");
        check("R9 jam dropped", int'(jam_req), 0);
        check("R9 no pause", int'(pause_req), 0);
        full_duplex = 1'b0;
        do_cycle(1'b0, 1'b1, adv(m_rd, 10), "R3 hold", "R8");
        do_cycle(1'b0, 1'b0, m_rd, "R3 hold", "R8");
        check("R8 jam released", int'(jam_req), 0);
        random_run(600, 1'b0, "R8");

        // 64-byte slots, threshold zero: flow control off
        do_reset(16'h0400, 16'h0800, 8'h80, 1'b1);
        random_run(500, 1'b1, "R6");

        // 128-byte slots, threshold 4
        do_reset(16'h1000, 16'h1C00, 8'h44, 1'b0);
        random_run(800, 1'b1, "R9");

        finish_run();
    end
endmodule